// File: doc/BRIEF.md
# Key Matrix Scanner With Double-Scan Confirmation

This block watches a keypad wired as a grid of drive lines (outputs) and sense lines (inputs). While no key is down it holds the drive lines at a standby level and does nothing else. When any sense line goes high, it starts a confirmation round. A round contains two complete scans, and each scan raises one drive line at a time. If both scans give the same non-empty key set, the block publishes that set as a flat key vector and pulls an active-low read request toward a host. If the two scans differ, it runs another round. If both scans come back empty, the press is treated as noise and the block returns to idle without a request.

Time is counted in oscillator ticks, one per clock. The block can be placed in one of three sleep standby patterns. Each pattern keeps only some drive lines high, so only keys on those lines can wake the scanner. The published result carries a flag telling whether the wake-up happened while asleep. One or two of the lowest drive lines can be given over to another function. They then stay low and their keys always read as released. The host drops the request by pulsing a read-done input. That pulse also starts a fresh round, which reports a new result if keys are still held. A serial-busy input hides the request while a transfer is under way.

Top module: `kbd_matrix_scanner`

## Requirements
- R1: While `rst_n` is low, `keys_o` is cleared, `sleep_ack_o` is 0, `req_n_o` is high, and no round starts even if a sense line is high.
- R2: In idle, `drive_o` follows `sleep_sel_i`. Value 00 sets every line high. Value 01 sets only the top line high (`drive_o[5]` with six lines). Value 10 sets the top two lines high (bits 5:4). Value 11 sets every line except line 1 high (bits 5:1).
- R3: `seg_steal_i` hands lines to another function. Value 00 hands over none. Value 01 hands over line 1 (`drive_o[0]`). Values 10 and 11 hand over lines 1 and 2 (bits 1:0). A handed-over line is always driven low. Its key bits read 0 (bits 4:0 for line 1, bits 9:5 for line 2). A press on it alone never starts a round.
- R4: From idle, a round starts on the clock edge that first sees any sense line high. A press on a drive line that is low in the current standby pattern starts nothing.
- R5: During each scan, the lines are raised one at a time in ascending order, SCAN_TICKS/NUM_DRV ticks each, with all other lines low. A key at drive line d and sense line s (both counted from 1) is reported as 1 at `keys_o` bit (d-1)*NUM_SNS+(s-1).
- R6: When the two scans of a round agree on a non-empty set, `keys_o` and `sleep_ack_o` are updated and `req_n_o` falls on the CONFIRM_TICKS-th edge after the edge that started the round. `keys_o` changes at no other time.
- R7: When the two scans of a round disagree, a new round follows at once. The request then falls 2*CONFIRM_TICKS edges after the start if the second round agrees.
- R8: When the two scans agree that no key is down, the block returns to idle with no request, and `keys_o` is unchanged.
- R9: `sleep_ack_o` is 1 when `sleep_sel_i` was non-zero at the edge that woke the scanner from idle, and 0 otherwise.
- R10: While `xfer_busy_i` is high, `req_n_o` is high. A pending request shows again when `xfer_busy_i` falls.
- R11: A `rd_done_i` pulse while a request is pending clears the request and starts a new round on that edge. A pulse with nothing pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sense_i | input | NUM_SNS | Sense line levels, high where a pressed key meets a high drive line |
| sleep_sel_i | input | 2 | Standby pattern select, 00 normal |
| seg_steal_i | input | 2 | Drive lines handed over: 00 none, 01 line 1, 1x lines 1-2 |
| rd_done_i | input | 1 | Host finished reading the key vector |
| xfer_busy_i | input | 1 | Serial transfer in progress |
| drive_o | output | NUM_DRV | Drive line levels |
| keys_o | output | NUM_DRV*NUM_SNS | Confirmed key vector |
| sleep_ack_o | output | 1 | Result was woken from sleep |
| req_n_o | output | 1 | Active-low read request |

## Verification
The bench keeps the full six-by-five grid but shortens the timing to SCAN_TICKS=14 and CONFIRM_TICKS=32, so each line gets a two-tick slot. These short windows allow many rounds in one run. They also make it possible to change the held keys between the first and second scan of a round, which forces a disagreement that sends the scanner into a second round. A bench model turns pressed keys into sense levels from the live drive lines. Wake gating in each sleep pattern, and masking of handed-over lines, are therefore checked against the real line levels and not against a shortcut.

// File: rtl/kbs_pkg.sv
// Package: shared state encoding for the key matrix scanner.
// Assumes one clock tick per oscillator period.
package kbs_pkg;

    typedef enum logic [1:0] {
        KBS_IDLE = 2'd0,   // standby pattern on drive lines, waiting for a press
        KBS_SCAN = 2'd1,   // confirmation round in progress
        KBS_PEND = 2'd2    // result published, waiting for the host
    } kbs_state_e;

endpackage

// File: rtl/kbs_tick_timer.sv
// Module: round and scan tick timer.
// Counts one confirmation round of CONFIRM_TICKS ticks. The round holds two
// scans of SCAN_TICKS ticks; each scan gives every drive line a slot of
// SCAN_TICKS/NUM_DRV ticks, and leftover ticks are idle.
// Assumes CONFIRM_TICKS >= 2*SCAN_TICKS and SCAN_TICKS >= NUM_DRV.
// All counters are held at zero while run_i is low.
module kbs_tick_timer #(
    parameter int NUM_DRV       = 6,
    parameter int SCAN_TICKS    = 375,
    parameter int CONFIRM_TICKS = 800
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run_i,
    output logic [$clog2(NUM_DRV+1)-1:0] slot_o,
    output logic                         slot_valid_o,
    output logic                         sample_o,
    output logic                         pass_o,
    output logic                         round_end_o
);
    localparam int SLOT_TICKS = SCAN_TICKS / NUM_DRV;
    localparam int RT_W       = $clog2(CONFIRM_TICKS);
    localparam int ST_W       = $clog2(SCAN_TICKS);
    localparam int SK_W       = $clog2(SLOT_TICKS + 1);
    localparam int SL_W       = $clog2(NUM_DRV + 1);

    logic [RT_W-1:0] round_tick;
    logic [ST_W-1:0] scan_tick;
    logic [SK_W-1:0] slot_tick;
    logic [SL_W-1:0] slot;
    logic [1:0]      pass;

    logic last_round_tick;
    logic last_scan_tick;
    logic last_slot_tick;

    // Purpose: decode the end of each counting window.
    always_comb begin
        last_round_tick = (round_tick == RT_W'(CONFIRM_TICKS - 1));
        last_scan_tick  = (scan_tick == ST_W'(SCAN_TICKS - 1));
        last_slot_tick  = (slot_tick == SK_W'(SLOT_TICKS - 1));
    end

    // Purpose: advance round, scan and slot counters while a round runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || last_round_tick) begin
            round_tick <= '0;
            scan_tick  <= '0;
            slot_tick  <= '0;
            slot       <= '0;
            pass       <= '0;
        end else begin
            round_tick <= round_tick + 1'b1;
            if (last_scan_tick) begin
                scan_tick <= '0;
                slot_tick <= '0;
                slot      <= '0;
                if (pass != 2'd2) begin
                    pass <= pass + 1'b1;
                end
            end else begin
                scan_tick <= scan_tick + 1'b1;
                if (slot < SL_W'(NUM_DRV)) begin
                    if (last_slot_tick) begin
                        slot_tick <= '0;
                        slot      <= slot + 1'b1;
                    end else begin
                        slot_tick <= slot_tick + 1'b1;
                    end
                end
            end
        end
    end

    // Purpose: expose slot decode and strobes to the capture and control logic.
    always_comb begin
        slot_o       = slot;
        slot_valid_o = run_i && (pass != 2'd2) && (slot < SL_W'(NUM_DRV));
        sample_o     = slot_valid_o && last_slot_tick;
        pass_o       = pass[0];
        round_end_o  = run_i && last_round_tick;
    end

endmodule

// File: rtl/kbs_scan_capture.sv
// Module: two-scan result capture.
// Stores the sense levels seen at the last tick of each drive line slot, once
// for the first scan of a round and once for the second. Lines handed to
// another function are masked to zero on the outputs.
module kbs_scan_capture #(
    parameter int NUM_DRV = 6,
    parameter int NUM_SNS = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample_i,
    input  logic                         pass_i,
    input  logic [$clog2(NUM_DRV+1)-1:0] slot_i,
    input  logic [NUM_SNS-1:0]           sense_i,
    input  logic [NUM_DRV-1:0]           line_mask_i,
    output logic [NUM_DRV*NUM_SNS-1:0]   scan_a_o,
    output logic [NUM_DRV*NUM_SNS-1:0]   scan_b_o
);
    localparam int SL_W = $clog2(NUM_DRV + 1);

    for (genvar d = 0; d < NUM_DRV; d++) begin : g_line
        logic [NUM_SNS-1:0] a_q;
        logic [NUM_SNS-1:0] b_q;
        logic               hit;

        assign hit = sample_i && (slot_i == SL_W'(d));

        // Purpose: latch this line's sense levels into the scan slot in use.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q <= '0;
                b_q <= '0;
            end else if (hit && !pass_i) begin
                a_q <= sense_i;
            end else if (hit && pass_i) begin
                b_q <= sense_i;
            end
        end

        assign scan_a_o[d*NUM_SNS +: NUM_SNS] = line_mask_i[d] ? '0 : a_q;
        assign scan_b_o[d*NUM_SNS +: NUM_SNS] = line_mask_i[d] ? '0 : b_q;
    end

endmodule

// File: rtl/kbs_drive_pattern.sv
// Module: drive line level generator.
// In idle and while a request is pending, presents the standby pattern chosen
// by the sleep select. During a round, raises only the line whose slot is
// active. Handed-over lines are always low.
// Assumes NUM_DRV >= 2.
module kbs_drive_pattern #(
    parameter int NUM_DRV = 6
) (
    input  logic [1:0]                   sleep_sel_i,
    input  logic [1:0]                   seg_steal_i,
    input  logic                         scan_act_i,
    input  logic                         slot_valid_i,
    input  logic [$clog2(NUM_DRV+1)-1:0] slot_i,
    output logic [NUM_DRV-1:0]           line_mask_o,
    output logic [NUM_DRV-1:0]           drive_o
);
    localparam int SL_W = $clog2(NUM_DRV + 1);

    logic [NUM_DRV-1:0] standby;
    logic [NUM_DRV-1:0] scan_line;

    for (genvar d = 0; d < NUM_DRV; d++) begin : g_line
        localparam logic TOP_ONE  = (d == NUM_DRV - 1);
        localparam logic TOP_TWO  = (d >= NUM_DRV - 2);
        localparam logic NOT_LOW  = (d >= 1);
        localparam logic STEAL_01 = (d == 0);
        localparam logic STEAL_1X = (d <= 1);

        // Purpose: decide whether this line is handed over to another function.
        always_comb begin
            unique case (seg_steal_i)
                2'b00:   line_mask_o[d] = 1'b0;
                2'b01:   line_mask_o[d] = STEAL_01;
                default: line_mask_o[d] = STEAL_1X;
            endcase
        end

        // Purpose: standby level of this line for the selected sleep pattern.
        always_comb begin
            unique case (sleep_sel_i)
                2'b00:   standby[d] = 1'b1;
                2'b01:   standby[d] = TOP_ONE;
                2'b10:   standby[d] = TOP_TWO;
                default: standby[d] = NOT_LOW;
            endcase
        end

        assign scan_line[d] = slot_valid_i && (slot_i == SL_W'(d));
    end

    // Purpose: select between scan strobe and standby, masking handed-over lines.
    always_comb begin
        if (scan_act_i) begin
            drive_o = scan_line & ~line_mask_o;
        end else begin
            drive_o = standby & ~line_mask_o;
        end
    end

endmodule

// File: rtl/kbd_matrix_scanner.sv
// Module: key matrix scanner with double-scan confirmation (top).
// Waits in idle until a sense line rises, then runs confirmation rounds of two
// scans. An agreeing, non-empty result is published with an active-low read
// request; an agreeing empty result returns to idle; a disagreement repeats
// the round. The host clears the request with rd_done_i, which also starts a
// new round. Assumes one clock per oscillator tick and a synchronous reset.
module kbd_matrix_scanner #(
    parameter int NUM_DRV       = 6,
    parameter int NUM_SNS       = 5,
    parameter int SCAN_TICKS    = 375,
    parameter int CONFIRM_TICKS = 800
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SNS-1:0]         sense_i,
    input  logic [1:0]                 sleep_sel_i,
    input  logic [1:0]                 seg_steal_i,
    input  logic                       rd_done_i,
    input  logic                       xfer_busy_i,
    output logic [NUM_DRV-1:0]         drive_o,
    output logic [NUM_DRV*NUM_SNS-1:0] keys_o,
    output logic                       sleep_ack_o,
    output logic                       req_n_o
);
    import kbs_pkg::*;

    localparam int NUM_KEYS = NUM_DRV * NUM_SNS;
    localparam int SL_W     = $clog2(NUM_DRV + 1);

    kbs_state_e          state;
    logic                wake_in_sleep;
    logic                scan_act;
    logic                idle_act;
    logic [SL_W-1:0]     slot;
    logic                slot_valid;
    logic                sample;
    logic                pass;
    logic                round_end;
    logic [NUM_DRV-1:0]  line_mask;
    logic [NUM_KEYS-1:0] scan_a;
    logic [NUM_KEYS-1:0] scan_b;
    logic                scans_agree;
    logic                scans_empty;

    assign scan_act = (state == KBS_SCAN);
    assign idle_act = (state == KBS_IDLE);

    kbs_tick_timer #(
        .NUM_DRV       (NUM_DRV),
        .SCAN_TICKS    (SCAN_TICKS),
        .CONFIRM_TICKS (CONFIRM_TICKS)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (scan_act),
        .slot_o       (slot),
        .slot_valid_o (slot_valid),
        .sample_o     (sample),
        .pass_o       (pass),
        .round_end_o  (round_end)
    );

    kbs_drive_pattern #(
        .NUM_DRV (NUM_DRV)
    ) u_drive (
        .sleep_sel_i  (sleep_sel_i),
        .seg_steal_i  (seg_steal_i),
        .scan_act_i   (scan_act),
        .slot_valid_i (slot_valid),
        .slot_i       (slot),
        .line_mask_o  (line_mask),
        .drive_o      (drive_o)
    );

    kbs_scan_capture #(
        .NUM_DRV (NUM_DRV),
        .NUM_SNS (NUM_SNS)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_i    (sample),
        .pass_i      (pass),
        .slot_i      (slot),
        .sense_i     (sense_i),
        .line_mask_i (line_mask),
        .scan_a_o    (scan_a),
        .scan_b_o    (scan_b)
    );

    // Purpose: compare the two scans of the round that is ending.
    always_comb begin
        scans_agree = (scan_a == scan_b);
        scans_empty = (scan_a == '0);
    end

    // Purpose: round sequencing, result publication and wake flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= KBS_IDLE;
            keys_o        <= '0;
            sleep_ack_o   <= 1'b0;
            wake_in_sleep <= 1'b0;
        end else begin
            unique case (state)
                KBS_IDLE: begin
                    if (|sense_i) begin
                        state         <= KBS_SCAN;
                        wake_in_sleep <= (sleep_sel_i != 2'b00);
                    end
                end
                KBS_SCAN: begin
                    if (round_end && scans_agree) begin
                        if (scans_empty) begin
                            state <= KBS_IDLE;
                        end else begin
                            state       <= KBS_PEND;
                            keys_o      <= scan_a;
                            sleep_ack_o <= wake_in_sleep;
                        end
                    end
                end
                KBS_PEND: begin
                    if (rd_done_i) begin
                        state <= KBS_SCAN;
                    end
                end
                default: state <= KBS_IDLE;
            endcase
        end
    end

    // Purpose: active-low request, hidden during a serial transfer.
    assign req_n_o = (state != KBS_PEND) || xfer_busy_i;

endmodule

// File: rtl/kbs_checker.sv
// Module: property checker for the key matrix scanner, bound to the top.
// Watches ports plus the idle/scan state flags.
module kbs_checker #(
    parameter int NUM_DRV = 6,
    parameter int NUM_SNS = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_DRV-1:0]         drive_o,
    input logic [NUM_DRV*NUM_SNS-1:0] keys_o,
    input logic                       req_n_o,
    input logic                       xfer_busy_i,
    input logic [1:0]                 sleep_sel_i,
    input logic [1:0]                 seg_steal_i,
    input logic                       scan_act,
    input logic                       idle_act
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (keys_o == '0) && req_n_o); // R1

    AST_SLEEP_TOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_act && sleep_sel_i == 2'b01) |-> (drive_o[NUM_DRV-2:0] == '0)); // R2

    AST_STOLEN_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_steal_i != 2'b00) |-> !drive_o[0]); // R3

    AST_STOLEN_KEYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_steal_i[1] && !$stable(keys_o)) |-> (keys_o[2*NUM_SNS-1:0] == '0)); // R3

    AST_SCAN_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_act |-> $onehot0(drive_o)); // R5

    AST_KEYS_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(keys_o) |-> (!req_n_o || xfer_busy_i)); // R6

endmodule

bind kbd_matrix_scanner kbs_checker #(
    .NUM_DRV (NUM_DRV),
    .NUM_SNS (NUM_SNS)
) u_kbs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .drive_o     (drive_o),
    .keys_o      (keys_o),
    .req_n_o     (req_n_o),
    .xfer_busy_i (xfer_busy_i),
    .sleep_sel_i (sleep_sel_i),
    .seg_steal_i (seg_steal_i),
    .scan_act    (scan_act),
    .idle_act    (idle_act)
);

// File: tb/kbd_matrix_scanner_bench.sv
module kbd_matrix_scanner_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ND   = 6;
    localparam int NS   = 5;
    localparam int NK   = ND * NS;
    localparam int SCAN = 14;
    localparam int CONF = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] sense;
    logic [1:0]    sleep_sel = 2'b00;
    logic [1:0]    steal = 2'b00;
    logic          rd_done = 1'b0;
    logic          busy = 1'b0;
    logic [ND-1:0] drive;
    logic [NK-1:0] keys;
    logic          sack;
    logic          req_n;
    logic [NK-1:0] pressed = '0;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Keypad model: a pressed key passes its drive line level to its sense line.
    always_comb begin
        sense = '0;
        for (int d = 0; d < ND; d++)
            for (int s = 0; s < NS; s++)
                if (pressed[d*NS+s] && drive[d]) sense[s] = 1'b1;
    end

    kbd_matrix_scanner #(
        .NUM_DRV(ND), .NUM_SNS(NS), .SCAN_TICKS(SCAN), .CONFIRM_TICKS(CONF)
    ) u_kbd_matrix_scanner (
        .clk(clk), .rst_n(rst_n), .sense_i(sense), .sleep_sel_i(sleep_sel),
        .seg_steal_i(steal), .rd_done_i(rd_done), .xfer_busy_i(busy),
        .drive_o(drive), .keys_o(keys), .sleep_ack_o(sack), .req_n_o(req_n)
    );

    function automatic logic [ND-1:0] exp_standby(input logic [1:0] sel, input logic [1:0] st);
        logic [ND-1:0] p;
        case (sel)
            2'b00:   p = '1;
            2'b01:   p = 6'b100000;
            2'b10:   p = 6'b110000;
            default: p = 6'b111110;
        endcase
        if (st != 2'b00) p[0] = 1'b0;
        if (st[1])       p[1] = 1'b0;
        return p;
    endfunction

    function automatic logic [NK-1:0] exp_keep(input logic [1:0] st);
        logic [NK-1:0] m = '1;
        if (st != 2'b00) m[NS-1:0] = '0;
        if (st[1])       m[2*NS-1:NS] = '0;
        return m;
    endfunction

    function automatic logic wakes(input logic [NK-1:0] p, input logic [ND-1:0] sb);
        logic w = 1'b0;
        for (int d = 0; d < ND; d++)
            if (sb[d] && (p[d*NS +: NS] != '0)) w = 1'b1;
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Counts clock edges until the request is seen low, at most maxn.
    task automatic wait_req(input int maxn, output int n);
        n = 0;
        while (n < maxn) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (!req_n) break;
        end
    endtask

    task automatic quiet(input int cycles, input string req);
        bit seen = 1'b0;
        repeat (cycles) begin
            @(negedge clk);
            if (!req_n) seen = 1'b1;
        end
        chk(!seen, req, {31'd0, seen}, 32'd0);
    endtask

    task automatic pulse_rd();
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
    endtask

    task automatic settle();
        pressed = '0;
        if (!req_n) pulse_rd();
        repeat (CONF + 4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        logic [NK-1:0] prev;
        void'($urandom(32'd2718));

        // R1: held reset with a key down starts nothing
        pressed = 30'd1;
        quiet(3 * CONF, "R1");
        pressed = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(keys == '0, "R1", 32'(keys), 0);
        chk(sack == 1'b0, "R1", 32'(sack), 0);
        chk(req_n == 1'b1, "R1", 32'(req_n), 1);
        chk(drive == 6'h3f, "R2", 32'(drive), 32'h3f);

        // R4 R5 R6 R9: single key, line 3 sense 2 -> bit 11
        pressed = 30'd1 << 11;
        wait_req(CONF + 5, n);
        chk(!req_n && n == CONF + 1, "R6", n, CONF + 1);
        chk(keys == (30'd1 << 11), "R5", 32'(keys), 32'(30'd1 << 11));
        chk(sack == 1'b0, "R9", 32'(sack), 0);

        // R10: busy hides a pending request
        busy = 1'b1;
        #1 chk(req_n == 1'b1, "R10", 32'(req_n), 1);
        @(negedge clk);
        busy = 1'b0;
        #1 chk(req_n == 1'b0, "R10", 32'(req_n), 0);

        // R11: read done restarts a round; line 2 sense 3 -> bit 7
        pressed = 30'd1 << 7;
        pulse_rd();
        wait_req(CONF + 5, n);
        chk(!req_n && n == CONF, "R11", n, CONF);
        chk(keys == (30'd1 << 7), "R5", 32'(keys), 32'(30'd1 << 7));

        // R8: release then read -> empty round, idle, keys kept
        pressed = '0;
        pulse_rd();
        quiet(2 * CONF, "R8");
        chk(keys == (30'd1 << 7), "R8", 32'(keys), 32'(30'd1 << 7));

        // R11: read done with nothing pending is ignored
        pulse_rd();
        quiet(2 * CONF, "R11");
        chk(keys == (30'd1 << 7), "R11", 32'(keys), 32'(30'd1 << 7));

        // R7: second key appears between the two scans
        pressed = 30'd1 << 10;
        n = 0;
        while (n < 3 * CONF) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == SCAN + 2) pressed = pressed | (30'd1 << 25);
            if (!req_n) break;
        end
        chk(!req_n && n == 2 * CONF + 1, "R7", n, 2 * CONF + 1);
        chk(keys == ((30'd1 << 10) | (30'd1 << 25)), "R7", 32'(keys), 32'((30'd1 << 10) | (30'd1 << 25)));
        settle();

        // R8: one-tick tap gives an empty round, no request
        prev = keys;
        pressed = 30'd1 << 12;
        @(negedge clk);
        pressed = '0;
        quiet(3 * CONF, "R8");
        chk(keys == prev, "R8", 32'(keys), 32'(prev));

        // R3: line 1 handed over
        steal = 2'b01;
        @(negedge clk);
        chk(drive == 6'h3e, "R3", 32'(drive), 32'h3e);
        pressed = 30'd1 << 2;
        quiet(2 * CONF, "R3");
        pressed = pressed | (30'd1 << 17);
        wait_req(CONF + 5, n);
        chk(!req_n && n == CONF + 1, "R3", n, CONF + 1);
        chk(keys == (30'd1 << 17), "R3", 32'(keys), 32'(30'd1 << 17));
        settle();
        steal = 2'b10;
        @(negedge clk);
        chk(drive == 6'h3c, "R3", 32'(drive), 32'h3c);
        pressed = (30'd1 << 3) | (30'd1 << 8) | (30'd1 << 20);
        wait_req(CONF + 5, n);
        chk(keys == (30'd1 << 20), "R3", 32'(keys), 32'(30'd1 << 20));
        settle();
        steal = 2'b00;

        // R2 R4 R9: sleep patterns and wake gating
        sleep_sel = 2'b01;
        @(negedge clk);
        chk(drive == 6'h20, "R2", 32'(drive), 32'h20);
        pressed = 30'd1 << 1;
        quiet(2 * CONF, "R4");
        pressed = pressed | (30'd1 << 27);
        wait_req(CONF + 5, n);
        chk(!req_n && n == CONF + 1, "R4", n, CONF + 1);
        chk(keys == ((30'd1 << 1) | (30'd1 << 27)), "R5", 32'(keys), 32'((30'd1 << 1) | (30'd1 << 27)));
        chk(sack == 1'b1, "R9", 32'(sack), 1);
        settle();
        sleep_sel = 2'b10;
        @(negedge clk);
        chk(drive == 6'h30, "R2", 32'(drive), 32'h30);
        sleep_sel = 2'b11;
        @(negedge clk);
        chk(drive == 6'h3e, "R2", 32'(drive), 32'h3e);
        pressed = 30'd1 << 1;
        quiet(2 * CONF, "R4");
        pressed = pressed | (30'd1 << 6);
        wait_req(CONF + 5, n);
        chk(keys == ((30'd1 << 1) | (30'd1 << 6)), "R4", 32'(keys), 32'((30'd1 << 1) | (30'd1 << 6)));
        chk(sack == 1'b1, "R9", 32'(sack), 1);
        settle();
        steal = 2'b10;
        @(negedge clk);
        chk(drive == 6'h3c, "R3", 32'(drive), 32'h3c);
        steal = 2'b00;
        sleep_sel = 2'b00;

        // Random patterns: R2 R3 R4 R5 R6 R9
        for (int it = 0; it < 24; it++) begin
            logic [ND-1:0] sb;
            logic [NK-1:0] p;
            sleep_sel = 2'($urandom_range(0, 3));
            steal = 2'($urandom_range(0, 3));
            p = '0;
            for (int k = 0; k < 3; k++) p[$urandom_range(0, NK - 1)] = 1'b1;
            @(negedge clk);
            sb = exp_standby(sleep_sel, steal);
            chk(drive == sb, "R2", 32'(drive), 32'(sb));
            prev = keys;
            pressed = p;
            if (wakes(p, sb)) begin
                wait_req(CONF + 5, n);
                chk(!req_n && n == CONF + 1, "R6", n, CONF + 1);
                chk(keys == (p & exp_keep(steal)), "R5", 32'(keys), 32'(p & exp_keep(steal)));
                chk(sack == (sleep_sel != 2'b00), "R9", 32'(sack), 32'(sleep_sel != 2'b00));
            end else begin
                quiet(2 * CONF, "R4");
                chk(keys == prev, "R4", 32'(keys), 32'(prev));
            end
            settle();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule